// File: doc/BRIEF.md
# Serial-Readout Logic State Capture Unit

This block records a parallel probe bus into an on-chip FIFO whenever an external capture clock rises. Recording runs on its own from the moment the FIFO is cleared until the FIFO fills. After that, new samples are dropped and the stored ones stay intact. A host reads the record back one byte at a time over an asynchronous serial line. To ask for the next byte, the host transmits the character 0xFF. The only low period in that character is its start bit, so the block treats each falling edge on its receive input as one read request and needs no full serial receiver.

A read request is held until the next baud tick. At that tick the block pops the oldest sample into a shift register and sends it as a standard asynchronous frame. A two-bit status output tells the host whether the FIFO is full or empty. Holding the clear input low empties the FIFO before a new capture begins.

The transmitter is a four-state machine with states TX_IDLE, TX_START, TX_DATA and TX_STOP:
- TX_IDLE moves to TX_START on a tick when a request is pending and the FIFO is not empty. That tick also pops the FIFO.
- TX_START moves to TX_DATA on the next tick.
- TX_DATA stays where it is for each data bit and moves to TX_STOP on the tick that ends the last data bit.
- TX_STOP moves back to TX_IDLE on the next tick.

Top module: `probe_serial_capture`

## Requirements
- R1: The probe bus is registered on each rising edge of `cap_clk`, and every such edge writes exactly one sample into the FIFO. The samples are read back in the order they were captured.
- R2: Samples are written until the FIFO holds DEPTH entries. Samples captured after that are discarded, and no stored sample is overwritten.
- R3: After reset, and whenever no byte is being sent, `tx_out` is high.
- R4: Each falling edge on `rx_in` is one read request. It is taken at the next baud tick and pops the oldest stored sample.
- R5: A popped byte is sent as one low start bit, then the 8 data bits least significant bit first, then one high stop bit. Each bit lasts BAUD_DIV system clock cycles.
- R6: The most significant data bit is sent from a separate hold latch that is loaded when the byte is popped, so the last data bit equals bit 7 of the popped sample.
- R7: A read request made while the FIFO is empty is ignored: no frame is sent and `tx_out` stays high.
- R8: A read request made while a frame is being sent is ignored: only one frame is sent, and the next stored sample stays in the FIFO for the following request.
- R9: While `clr_n` is low at a clock edge, the FIFO is emptied. Clear takes priority over a write in the same cycle.
- R10: `fifo_status[1]` is 1 exactly when the FIFO is full, and `fifo_status[0]` is 1 exactly when it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_clk | input | 1 | External capture clock; a sample is taken on its rising edge |
| probe | input | WIDTH | Parallel signals under observation |
| rx_in | input | 1 | Serial line from the host; a falling edge is a read request |
| clr_n | input | 1 | Synchronous FIFO clear, active low |
| tx_out | output | 1 | Serial line to the host; idles high |
| fifo_status | output | 2 | Bit 1 = FIFO full, bit 0 = FIFO empty |

## Verification
The main check captures a table of probe values and reads them back through the serial line:
- All zeros and all ones show whether the frame's start and stop bits are kept apart from the data.
- 0x01 against 0x80, and 0x3C against 0xC3, show whether the bit order is reversed or the held MSB is wrong.
- 0xA5 against 0x5A shows whether adjacent bits are swapped.

A sweep of 19 computed values against a FIFO of 16 entries shows whether samples past full are dropped rather than overwritten. Directed read requests made with an empty FIFO, made during a frame, and made after a clear show whether the pop is correctly gated in each of these cases.

// File: rtl/pscap_pkg.sv
package pscap_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/pscap_capture.sv
module pscap_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_clk,
    input  logic [WIDTH-1:0] probe,
    output logic [WIDTH-1:0] sample,
    output logic             wr_pulse
);
    // Probe register clocked by the board-side capture clock.
    logic [WIDTH-1:0] probe_q;

    always_ff @(posedge cap_clk) begin
        probe_q <= probe;
    end

    // Bring the capture clock into the system domain; one write per rising edge.
    logic [2:0] cap_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sync <= 3'b000;
        end else begin
            cap_sync <= {cap_sync[1:0], cap_clk};
        end
    end

    assign wr_pulse = cap_sync[1] & ~cap_sync[2];
    assign sample   = probe_q;
endmodule

// File: rtl/pscap_fifo.sv
module pscap_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr && !full && !clr) begin
            mem[wp[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr && !full) begin
                wp <= wp + 1'b1;
            end
            if (rd && !empty) begin
                rp <= rp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pscap_baud.sv
module pscap_baud #(
    parameter int BAUD_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BAUD_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/pscap_tx.sv
module pscap_tx
    import pscap_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_in,
    input  logic             fifo_empty,
    input  logic [WIDTH-1:0] fifo_data,
    output logic             pop,
    output logic             tx_out,
    output tx_state_t        state_o
);
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

    tx_state_t        state, nxt;
    logic [2:0]       rx_sync;
    logic             rx_fall, pending, req;
    logic [WIDTH-1:0] shreg;
    logic             msb_hold;
    logic [BW-1:0]    bitcnt;

    // Read strobe: synchronize the start-bit edge and hold it until a baud tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync <= 3'b111;
            pending <= 1'b0;
        end else begin
            rx_sync <= {rx_sync[1:0], rx_in};
            pending <= tick ? 1'b0 : (pending | rx_fall);
        end
    end

    assign rx_fall = rx_sync[2] & ~rx_sync[1];
    assign req     = pending | rx_fall;
    assign pop     = tick && (state == TX_IDLE) && req && !fifo_empty;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (pop)  nxt = TX_START;
            TX_START: if (tick) nxt = TX_DATA;
            TX_DATA:  if (tick && bitcnt == LAST_BIT) nxt = TX_STOP;
            TX_STOP:  if (tick) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // Shift register, MSB hold latch and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '1;
            msb_hold <= 1'b1;
            bitcnt   <= '0;
        end else if (pop) begin
            shreg    <= fifo_data;
            msb_hold <= fifo_data[WIDTH-1];
            bitcnt   <= '0;
        end else if (tick && state == TX_DATA && bitcnt != LAST_BIT) begin
            shreg    <= {1'b1, shreg[WIDTH-1:1]};
            bitcnt   <= bitcnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx_out = 1'b1;
        unique case (state)
            TX_IDLE:  tx_out = 1'b1;
            TX_START: tx_out = 1'b0;
            TX_DATA:  tx_out = (bitcnt == LAST_BIT) ? msb_hold : shreg[0];
            TX_STOP:  tx_out = 1'b1;
            default:  tx_out = 1'b1;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/probe_serial_capture.sv
module probe_serial_capture
    import pscap_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 16,
    parameter int BAUD_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_clk,
    input  logic [WIDTH-1:0] probe,
    input  logic             rx_in,
    input  logic             clr_n,
    output logic             tx_out,
    output logic [1:0]       fifo_status
);
    logic [WIDTH-1:0] sample, fifo_data;
    logic             wr_pulse, pop, tick, full, empty;
    tx_state_t        tx_state;

    pscap_capture #(.WIDTH(WIDTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk), .probe(probe),
        .sample(sample), .wr_pulse(wr_pulse)
    );

    pscap_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(!clr_n), .wr(wr_pulse), .wdata(sample),
        .rd(pop), .rdata(fifo_data), .full(full), .empty(empty)
    );

    pscap_baud #(.BAUD_DIV(BAUD_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pscap_tx #(.WIDTH(WIDTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .fifo_empty(empty), .fifo_data(fifo_data), .pop(pop),
        .tx_out(tx_out), .state_o(tx_state)
    );

    assign fifo_status = {full, empty};
endmodule

// File: rtl/pscap_checker.sv
module pscap_checker
    import pscap_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      clr_n,
    input logic      wr_pulse,
    input logic      pop,
    input logic      tick,
    input logic      full,
    input logic      empty,
    input logic      tx_out,
    input tx_state_t tx_state
);
    AST_ONE_WRITE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);                                                  // R1
    AST_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && clr_n) |=> full);                                        // R2
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == TX_IDLE && !pop) |=> tx_out);                                // R3
    AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> tick);                                                            // R4
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !tx_out);                                                         // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                                          // R7
    AST_NO_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state != TX_IDLE) |-> !pop);                                          // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> empty);                                                        // R9
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));                                                        // R10
endmodule

bind probe_serial_capture pscap_checker u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_pulse(wr_pulse), .pop(pop),
    .tick(tick), .full(full), .empty(empty), .tx_out(tx_out), .tx_state(tx_state)
);

// File: tb/sim_probe_serial_capture.sv
module sim_probe_serial_capture;
    localparam int WIDTH = 8;
    localparam int DEPTH = 16;
    localparam int DIV   = 8;
    localparam int NVEC  = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                          8'h01, 8'h80, 8'h3C, 8'hC3};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_clk = 1'b0;
    logic [WIDTH-1:0] probe = '0;
    logic             rx_in = 1'b1;
    logic             clr_n = 1'b1;
    logic             tx_out;
    logic [1:0]       fifo_status;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    probe_serial_capture #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BAUD_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_clk(cap_clk), .probe(probe),
        .rx_in(rx_in), .clr_n(clr_n), .tx_out(tx_out), .fifo_status(fifo_status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [7:0] v);
        @(negedge clk); probe = v;
        repeat (2) @(negedge clk);
        cap_clk = 1'b1;
        repeat (4) @(negedge clk);
        cap_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Request one byte; decode the frame. got_frame=0 when no start bit appears.
    task automatic read_byte(input bit poke, output logic [7:0] data,
                             output bit got_frame, output bit framing_ok,
                             output bit idle_after);
        int wait_n;
        data = '0; got_frame = 0; framing_ok = 1; idle_after = 1;
        @(negedge clk); rx_in = 1'b0;
        @(negedge clk); @(negedge clk); rx_in = 1'b1;
        wait_n = 0;
        while (tx_out === 1'b1 && wait_n < 4 * DIV) begin
            @(negedge clk); wait_n++;
        end
        if (tx_out !== 1'b0) return;
        got_frame = 1;
        for (int n = 1; n <= 10 * DIV; n++) begin
            @(negedge clk);
            if (poke && n == 4 * DIV) rx_in = 1'b0;
            if (poke && n == 4 * DIV + 2) rx_in = 1'b1;
            for (int b = 0; b < 10; b++) begin
                if (n == b * DIV + DIV / 2) begin
                    if (b == 0 && tx_out !== 1'b0) framing_ok = 0;
                    if (b == 9 && tx_out !== 1'b1) framing_ok = 0;
                    if (b >= 1 && b <= 8) data[b-1] = tx_out;
                end
            end
        end
        for (int n = 0; n < 4 * DIV; n++) begin
            @(negedge clk);
            if (tx_out !== 1'b1) idle_after = 0;
        end
    endtask

    function automatic logic [7:0] sweep(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        logic [7:0] d;
        bit gf, fo, ia;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 tx idle after reset", 32'(tx_out), 32'd1);
        check("R10 status empty after reset", 32'(fifo_status), 32'b01);

        // Table walk: capture all, read back in order.
        for (int i = 0; i < NVEC; i++) capture(VEC[i]);
        check("R1 status after capture", 32'(fifo_status), 32'b00);
        for (int i = 0; i < NVEC; i++) begin
            read_byte(0, d, gf, fo, ia);
            check("R4 frame sent", 32'(gf), 32'd1);
            check("R5 framing", 32'(fo), 32'd1);
            check("R1 R5 R6 data", 32'(d), 32'(VEC[i]));
            check("R3 idle after frame", 32'(ia), 32'd1);
        end
        check("R1 exactly one write per edge", 32'(fifo_status), 32'b01);
        read_byte(0, d, gf, fo, ia);
        check("R7 empty read ignored", 32'(gf), 32'd0);
        check("R7 line high", 32'(tx_out), 32'd1);

        // Overfill: 19 samples into 16 entries.
        for (int i = 0; i < DEPTH + 3; i++) capture(sweep(i));
        check("R2 R10 full status", 32'(fifo_status), 32'b10);
        for (int i = 0; i < DEPTH; i++) begin
            read_byte(0, d, gf, fo, ia);
            check("R2 no overwrite", 32'(d), 32'(sweep(i)));
        end
        check("R2 dropped extras", 32'(fifo_status), 32'b01);

        // Request during frame.
        capture(8'h11); capture(8'h22); capture(8'h33);
        read_byte(1, d, gf, fo, ia);
        check("R8 first byte", 32'(d), 32'h11);
        check("R8 no second frame", 32'(ia), 32'd1);
        read_byte(0, d, gf, fo, ia);
        check("R8 next sample kept", 32'(d), 32'h22);

        // Clear.
        capture(8'h44);
        check("R9 not empty before clear", 32'(fifo_status[0]), 32'd0);
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        check("R9 R10 empty after clear", 32'(fifo_status), 32'b01);
        read_byte(0, d, gf, fo, ia);
        check("R9 no frame after clear", 32'(gf), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule